// File: doc/BRIEF.md
# Command-Word SPI Master

This block is an SPI bus master fed by 32-bit command words. Each word carries the transmit data for one frame together with the chip-select pattern for that frame and a flag saying whether the select stays asserted after the frame ends. Words wait in a four-entry transmit queue. The shift engine takes them one at a time and sends each one as a frame of 1 to 16 bits. The bits received during the frame are right-aligned and placed in a receive queue, which software or a bus wrapper drains one word at a time.

Clock polarity, clock phase, bit order, frame length and the idle level of each select are configuration inputs. They must be held steady while a frame is running. The SCK rate comes from an external timing block as a one-cycle strobe, `sck_tick_i`. Every engine step (select setup, each clock half-period and the closing step) uses one strobe. A halt input stops new frames from starting. Two flush pulses empty the transmit queue and the receive queue. Occupancy counts, a sticky overflow flag for the transmit queue and a running flag are the status outputs.

Because the hold flag travels inside each command word, a multi-frame transaction to one device keeps its select asserted from frame to frame. The producer never has to toggle the select by hand.

Top module: `spi_cmd_master`

## Requirements
- R1: Command word layout. Bits [15:0] hold the transmit data and bits [21:16] hold the select pattern (bit 16 is select 0). Bit 31 is the hold flag. Bits [30:28] are a timing-set selector; it is accepted but has no effect, because only one timing set exists. Each frame is `frame_size_i`+1 bits long: 7 gives 8 bits and 15 gives 16 bits.
- R2: While no frame is shifting, `sck_o` rests at `cpol_i`. With `cpha_i`=0, MOSI changes on the trailing edge and both sides sample on the leading edge. With `cpha_i`=1, MOSI changes on the leading edge and both sides sample on the trailing edge.
- R3: With `lsb_first_i`=1, bit 0 of the frame goes first. Otherwise bit `frame_size_i` goes first. Received bits are stored in the same positions.
- R4: The idle level of `cs_o[i]` is `cs_idle_hi_i[i]`, and the asserted level is its inverse. During a frame, only the selects named in that frame's command word are asserted.
- R5: If the hold flag is set, the selects stay asserted after the frame until the next command word starts. A transmit flush while the engine is idle also releases them. If the hold flag is clear, the selects are released when the frame ends.
- R6: While `halt_i` is high, no new frame starts and the queued words stay queued. A frame that has already started runs to completion.
- R7: The transmit queue holds 4 words and `tx_count_o` shows how many it holds. A push into a full queue is dropped and sets `tx_overflow_o`, which stays set until `flush_tx_i`. A flush empties the queue and clears the flag.
- R8: Each finished frame adds one entry to the receive queue, and `rx_count_o` shows how many entries are waiting. A frame that finds the queue full (4 entries) is discarded. `pop_i` loads the head entry into `pop_data_o` on the next cycle; a pop from an empty queue loads 0. `flush_rx_i` empties the queue.
- R9: `running_o` is high while a frame is in progress or a select is being held.
- R10: After reset, both counts are 0, `tx_overflow_o` and `running_o` are 0, `mosi_o` is 0, `sck_o` equals `cpol_i`, and every select is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_tick_i | input | 1 | One-cycle strobe from the timing block; each strobe advances the engine one step |
| halt_i | input | 1 | Blocks new frames from starting |
| flush_tx_i | input | 1 | Pulse: empty the transmit queue, clear the overflow flag, release a held select |
| flush_rx_i | input | 1 | Pulse: empty the receive queue |
| cs_idle_hi_i | input | CS_N | Idle level of each select |
| frame_size_i | input | FSZ_W | Frame length minus one |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase (selects the sampling edge) |
| lsb_first_i | input | 1 | Bit order |
| push_i | input | 1 | Write `push_word_i` into the transmit queue |
| push_word_i | input | 32 | Command word |
| pop_i | input | 1 | Take one entry from the receive queue |
| pop_data_o | output | FRAME_W | Last popped receive word |
| tx_count_o | output | TXC_W | Transmit queue occupancy |
| rx_count_o | output | RXC_W | Receive queue occupancy |
| tx_overflow_o | output | 1 | Sticky push-when-full flag |
| running_o | output | 1 | Frame in progress or select held |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | CS_N | Chip selects |

## Verification
The bench drives all four clock modes in turn, together with frame lengths of 5, 8 and 16 bits and both bit orders. A slave model on the pins captures each frame and replies with a different word each time, so a wrong sampling edge, a swapped bit order or an off-by-one length shows up as a data mismatch in one direction or the other. Select patterns are tried on several lines, one of them idle-low, which exposes polarity errors and selects that should not be asserted. Runs of frames with and without the hold flag are told apart by counting select release edges. Halt, queue overflow, receive overflow, flushes and a pop from an empty queue are each exercised with the engine otherwise quiet, so that each effect is visible at the ports on its own.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int CS_LSB   = 16;
  localparam int HOLD_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } eng_state_t;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_i,
  output logic [W-1:0]  rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (count_o == CW'(DEPTH));
  assign empty_o   = (count_o == '0);
  assign wr_ok     = wr_i && !full_o && !flush_i;
  assign rd_ok     = rd_i && !empty_o && !flush_i;
  assign rd_data_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (wr_ok) wr_ptr <= step(wr_ptr);
      if (rd_ok) rd_ptr <= step(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CS_N    = 6,
  parameter int FRAME_W = 16,
  localparam int FSZ_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               halt_i,
  input  logic               flush_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_i,
  input  logic [FSZ_W-1:0]   fsz_i,
  input  logic               ent_valid_i,
  input  logic [FRAME_W-1:0] ent_data_i,
  input  logic [CS_N-1:0]    ent_cs_i,
  input  logic               ent_hold_i,
  input  logic               miso_i,
  output logic               ent_pop_o,
  output logic               rx_push_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               sck_o,
  output logic               mosi_o,
  output logic [CS_N-1:0]    act_o,
  output logic               busy_o
);
  eng_state_t         st;
  logic [FRAME_W-1:0] tx_q;
  logic [FSZ_W-1:0]   idx_q, fsz_q;
  logic               half_q, hold_q, lsb_q, cpha_q;

  function automatic logic [FSZ_W-1:0] pos(input logic [FSZ_W-1:0] k);
    return lsb_q ? k : fsz_q - k;
  endfunction

  assign ent_pop_o = (st == ST_IDLE) && tick_i && !halt_i && ent_valid_i && !flush_i;
  assign busy_o    = (st != ST_IDLE) || (act_o != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tx_q      <= '0;
      rx_word_o <= '0;
      idx_q     <= '0;
      fsz_q     <= '0;
      half_q    <= 1'b0;
      hold_q    <= 1'b0;
      lsb_q     <= 1'b0;
      cpha_q    <= 1'b0;
      act_o     <= '0;
      sck_o     <= cpol_i;
      mosi_o    <= 1'b0;
      rx_push_o <= 1'b0;
    end else begin
      rx_push_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          sck_o <= cpol_i;
          if (flush_i) act_o <= '0;
          if (ent_pop_o) begin
            tx_q      <= ent_data_i;
            act_o     <= ent_cs_i;
            hold_q    <= ent_hold_i;
            fsz_q     <= fsz_i;
            lsb_q     <= lsb_i;
            cpha_q    <= cpha_i;
            idx_q     <= '0;
            half_q    <= 1'b0;
            rx_word_o <= '0;
            if (!cpha_i) mosi_o <= ent_data_i[lsb_i ? '0 : fsz_i];
            st        <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick_i) st <= ST_SHIFT;
        ST_SHIFT: if (tick_i) begin
          sck_o <= ~sck_o;
          if (!half_q) begin
            half_q <= 1'b1;
            if (!cpha_q) rx_word_o[pos(idx_q)] <= miso_i;
            else         mosi_o <= tx_q[pos(idx_q)];
          end else begin
            half_q <= 1'b0;
            if (cpha_q) rx_word_o[pos(idx_q)] <= miso_i;
            if (idx_q == fsz_q) st <= ST_TAIL;
            else begin
              idx_q <= idx_q + 1'b1;
              if (!cpha_q) mosi_o <= tx_q[pos(idx_q + 1'b1)];
            end
          end
        end
        ST_TAIL: if (tick_i) begin
          rx_push_o <= 1'b1;
          if (!hold_q) act_o <= '0;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_halt_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && halt_i) |=> (st == ST_IDLE));

  assert_sck_rest_R2: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SHIFT && $stable(cpol_i)) |-> (sck_o == cpol_i));

  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIFT && half_q && !cpha_q) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int CS_N     = 6,
  parameter int FRAME_W  = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int FSZ_W   = $clog2(FRAME_W),
  localparam int TXC_W   = $clog2(TX_DEPTH + 1),
  localparam int RXC_W   = $clog2(RX_DEPTH + 1),
  localparam int ENT_W   = 1 + CS_N + FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_tick_i,
  input  logic               halt_i,
  input  logic               flush_tx_i,
  input  logic               flush_rx_i,
  input  logic [CS_N-1:0]    cs_idle_hi_i,
  input  logic [FSZ_W-1:0]   frame_size_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic               push_i,
  input  logic [WORD_W-1:0]  push_word_i,
  input  logic               pop_i,
  output logic [FRAME_W-1:0] pop_data_o,
  output logic [TXC_W-1:0]   tx_count_o,
  output logic [RXC_W-1:0]   rx_count_o,
  output logic               tx_overflow_o,
  output logic               running_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [CS_N-1:0]    cs_o
);
  logic [ENT_W-1:0]   ent_in, ent_head;
  logic               tx_full, tx_empty, ent_pop;
  logic               rx_full, rx_empty, rx_push;
  logic [FRAME_W-1:0] rx_word, rx_head;
  logic [CS_N-1:0]    act;

  assign ent_in = {push_word_i[HOLD_BIT], push_word_i[CS_LSB +: CS_N], push_word_i[FRAME_W-1:0]};

  spi_cmd_fifo #(.W(ENT_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush_i(flush_tx_i),
    .wr_i(push_i), .wr_data_i(ent_in),
    .rd_i(ent_pop), .rd_data_o(ent_head),
    .count_o(tx_count_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_cmd_engine #(.CS_N(CS_N), .FRAME_W(FRAME_W)) u_eng (
    .clk(clk), .rst(rst), .tick_i(sck_tick_i), .halt_i(halt_i), .flush_i(flush_tx_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_i(lsb_first_i), .fsz_i(frame_size_i),
    .ent_valid_i(!tx_empty), .ent_data_i(ent_head[FRAME_W-1:0]),
    .ent_cs_i(ent_head[FRAME_W +: CS_N]), .ent_hold_i(ent_head[ENT_W-1]),
    .miso_i(miso_i), .ent_pop_o(ent_pop), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .sck_o(sck_o), .mosi_o(mosi_o), .act_o(act), .busy_o(running_o)
  );

  spi_cmd_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush_i(flush_rx_i),
    .wr_i(rx_push && !rx_full), .wr_data_i(rx_word),
    .rd_i(pop_i), .rd_data_o(rx_head),
    .count_o(rx_count_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign cs_o = cs_idle_hi_i ^ act;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_overflow_o <= 1'b0;
      pop_data_o    <= '0;
    end else begin
      if (flush_tx_i)                tx_overflow_o <= 1'b0;
      else if (push_i && tx_full)    tx_overflow_o <= 1'b1;
      if (pop_i) pop_data_o <= rx_empty ? '0 : rx_head;
    end
  end

  assert_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    (push_i && tx_full && !flush_tx_i) |=> tx_overflow_o);

  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_i && rx_count_o == '0 && !flush_rx_i) |=> (pop_data_o == '0));

  assert_word_known_R1: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !$isunknown(push_word_i));
endmodule

// File: tb/spi_cmd_master_bench.sv
module spi_cmd_master_bench;
  localparam int CS_N = 6;
  localparam int RXD  = 4;
  localparam int TXD  = 4;

  typedef struct {
    logic [15:0] d;
    logic [5:0]  cs;
    logic [15:0] resp;
  } item_t;

  logic        clk = 0, rst = 1, tick = 0;
  logic        halt = 0, flush_tx = 0, flush_rx = 0;
  logic [5:0]  cs_idle = 6'h3f;
  logic [3:0]  fsz = 4'd7;
  logic        cpol = 0, cpha = 0, lsb = 0;
  logic        push = 0, pop = 0;
  logic [31:0] word = '0;
  logic [15:0] pop_data;
  logic [2:0]  tx_count, rx_count;
  logic        ovf, running, sck, mosi;
  logic        miso = 0;
  logic [5:0]  cs;

  int total = 0, bad = 0, frames = 0, nsent = 0, asserts = 0, releases = 0, sck_edges = 0;
  item_t exp_q[$];
  logic [15:0] rx_q[$];

  spi_cmd_master u_spi_cmd_master (
    .clk(clk), .rst(rst), .sck_tick_i(tick), .halt_i(halt),
    .flush_tx_i(flush_tx), .flush_rx_i(flush_rx), .cs_idle_hi_i(cs_idle),
    .frame_size_i(fsz), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
    .push_i(push), .push_word_i(word), .pop_i(pop), .pop_data_o(pop_data),
    .tx_count_o(tx_count), .rx_count_o(rx_count), .tx_overflow_o(ovf),
    .running_o(running), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
  );

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // slave model and frame monitor
  wire sel_any = |(cs ^ cs_idle);
  logic prev_sel = 0, prev_sck = 0;
  logic [15:0] got = '0;
  int k = 0;

  always @(sel_any) begin
    if (sel_any === 1'b1) asserts++;
    else if (sel_any === 1'b0) releases++;
  end

  always @(sck or sel_any) begin
    int n;
    n = int'(fsz) + 1;
    if (sel_any === 1'b1 && prev_sel !== 1'b1) begin
      k = 0; got = '0;
      if (!cpha && exp_q.size() > 0) miso = exp_q[0].resp[lsb ? 0 : n-1];
    end else if (sel_any === 1'b1 && sck !== prev_sck && exp_q.size() > 0) begin
      sck_edges++;
      if (sck !== cpol) begin
        if (!cpha) got[lsb ? k : n-1-k] = mosi;
        else       miso = exp_q[0].resp[lsb ? k : n-1-k];
      end else begin
        if (cpha) got[lsb ? k : n-1-k] = mosi;
        k++;
        if (k == n) begin
          item_t it;
          logic [15:0] m;
          it = exp_q.pop_front();
          m  = 16'((32'd1 << n) - 1);
          check(got == (it.d & m), "R1 R2 R3 mosi frame", 32'(got), 32'(it.d & m));
          check((cs ^ cs_idle) == it.cs, "R4 select pattern", 32'(cs ^ cs_idle), 32'(it.cs));
          if (rx_q.size() < RXD) rx_q.push_back(it.resp & m);
          frames++;
          k = 0; got = '0;
          if (!cpha && exp_q.size() > 0) miso = exp_q[0].resp[lsb ? 0 : n-1];
        end else if (!cpha) miso = exp_q[0].resp[lsb ? k : n-1-k];
      end
    end
    prev_sel = sel_any;
    prev_sck = sck;
  end

  // driver
  task automatic push_raw(input logic [31:0] w);
    @(negedge clk); push = 1; word = w;
    @(negedge clk); push = 0;
  endtask

  task automatic send(input logic [15:0] d, input logic [5:0] sel, input bit hold, input logic [2:0] tsel);
    item_t it;
    while (tx_count == 3'(TXD)) @(negedge clk);
    it.d = d; it.cs = sel;
    it.resp = 16'h5A3C ^ 16'(nsent * 16'h1F35);
    nsent++;
    exp_q.push_back(it);
    push_raw({hold, tsel, 6'b0, sel, d});
  endtask

  task automatic wait_frames();
    int guard = 0;
    while (exp_q.size() > 0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (8) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    while (rx_q.size() > 0) begin
      logic [15:0] e;
      e = rx_q.pop_front();
      @(negedge clk); pop = 1;
      @(negedge clk); pop = 0;
      check(pop_data == e, tag, 32'(pop_data), 32'(e));
    end
  endtask

  task automatic mode(input logic p, input logic h, input logic l, input logic [3:0] f);
    @(negedge clk); cpol = p; cpha = h; lsb = l; fsz = f;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0, r0, f0, e0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check(tx_count == 0 && rx_count == 0, "R10 counts", {tx_count, rx_count}, 0);
    check(!ovf && !running, "R10 flags", {ovf, running}, 0);
    check(cs == cs_idle && sck == cpol && mosi == 0, "R10 pins", {cs, sck, mosi}, {cs_idle, 2'b00});

    // mode 0, 8 bits, MSB first (R1 R2 R3)
    mode(0, 0, 0, 4'd7);
    send(16'h00A5, 6'b000001, 0, 3'd0);
    send(16'h003C, 6'b000001, 0, 3'd0);
    send(16'h12F0, 6'b000001, 0, 3'd0);
    wait_frames();
    check(rx_count == 3, "R8 rx count", rx_count, 3);
    check(!running, "R9 idle after frames", running, 0);
    drain("R8 rx data mode0");

    // mode 3, 16 bits, LSB first
    mode(1, 1, 1, 4'd15);
    send(16'hBEEF, 6'b001000, 0, 3'd0);
    send(16'h8001, 6'b001000, 0, 3'd0);
    wait_frames();
    drain("R8 rx data mode3");

    // mode 1 and mode 2, 5-bit frames, ignored timing selector (R1)
    mode(0, 1, 0, 4'd4);
    send(16'hFF13, 6'b000010, 0, 3'd5);
    send(16'h0009, 6'b000010, 0, 3'd7);
    wait_frames();
    drain("R8 rx data mode1");
    mode(1, 0, 1, 4'd4);
    send(16'h0016, 6'b010000, 0, 3'd0);
    wait_frames();
    drain("R8 rx data mode2");

    // idle-low select on line 2 (R4)
    mode(0, 0, 0, 4'd7);
    @(negedge clk); cs_idle = 6'b111011;
    send(16'h0081, 6'b000100, 0, 3'd0);
    wait_frames();
    check(cs == 6'b111011, "R4 idle-low rest", cs, 6'b111011);
    drain("R8 rx data idle-low");
    @(negedge clk); cs_idle = 6'h3f;

    // hold across frames (R5 R9)
    a0 = asserts; r0 = releases;
    send(16'h0011, 6'b100000, 1, 3'd0);
    send(16'h0022, 6'b100000, 1, 3'd0);
    wait_frames();
    check(running && cs == 6'b011111, "R5 R9 select held", {running, cs}, {1'b1, 6'b011111});
    send(16'h0033, 6'b100000, 0, 3'd0);
    wait_frames();
    check(asserts - a0 == 1 && releases - r0 == 1, "R5 one select window",
          32'((asserts - a0) * 16 + (releases - r0)), 32'h11);
    check(!running && cs == 6'h3f, "R5 released", {running, cs}, 7'h3f);
    drain("R8 rx data held");

    // halt (R6)
    @(negedge clk); halt = 1;
    f0 = frames; e0 = sck_edges;
    send(16'h0044, 6'b000001, 0, 3'd0);
    send(16'h0055, 6'b000001, 0, 3'd0);
    repeat (40) @(negedge clk);
    check(tx_count == 2 && frames == f0 && sck_edges == e0 && cs == 6'h3f, "R6 halted",
          {tx_count, 8'(frames - f0)}, {3'd2, 8'd0});
    @(negedge clk); halt = 0;
    wait_frames();
    check(frames == f0 + 2, "R6 resumed", frames - f0, 2);
    drain("R8 rx data after halt");

    // overflow and transmit flush (R7)
    @(negedge clk); halt = 1;
    for (int i = 0; i < 5; i++) push_raw({16'h0001, 16'(i)});
    check(tx_count == 4, "R7 depth", tx_count, 4);
    check(ovf, "R7 overflow sticky", ovf, 1);
    @(negedge clk); flush_tx = 1;
    @(negedge clk); flush_tx = 0;
    check(tx_count == 0 && !ovf, "R7 flush", {tx_count, ovf}, 0);
    f0 = frames;
    @(negedge clk); halt = 0;
    repeat (40) @(negedge clk);
    check(frames == f0 && rx_count == 0, "R7 flushed words not sent", frames - f0, 0);

    // receive queue full (R8)
    mode(0, 0, 1, 4'd7);
    for (int i = 0; i < 5; i++) send(16'(8'h30 + i), 6'b000001, 0, 3'd0);
    wait_frames();
    check(rx_count == 4, "R8 rx full", rx_count, 4);
    drain("R8 rx data full");
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    check(pop_data == 0, "R8 pop empty", pop_data, 0);

    // receive flush (R8)
    send(16'h0077, 6'b000001, 0, 3'd0);
    send(16'h0066, 6'b000001, 0, 3'd0);
    wait_frames();
    check(rx_count == 2, "R8 rx before flush", rx_count, 2);
    @(negedge clk); flush_rx = 1;
    @(negedge clk); flush_rx = 0;
    rx_q.delete();
    check(rx_count == 0, "R8 rx flush", rx_count, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule